// File: doc/BRIEF.md
# MDIO Management Target (PHY Side)

This block is the management slave that sits inside a physical-layer device. It runs on the management clock and samples the bidirectional management data line on each rising edge. It looks for a start pattern, which may come after a long run of ones or may arrive with no such run. It decodes the operation, and it compares the device-address field with a 5-bit address strapped at its pins. When the address matches, it serves a read or a write on a 32-entry, 16-bit register file.

The pad is modelled as a separate input, output and output enable. The block releases the line while it listens. On a matching read it keeps the line released for the first turnaround bit, then drives the rest of the reply: a zero, and after it sixteen data bits, most significant bit first. It changes its drive only after falling clock edges, so the master sees stable data at each rising edge. A preload port lets on-chip logic write status values into any register, for example link state that the master polls.

The `rst_n` input is asynchronous and active low. It must be released synchronously to the management clock by the surrounding logic.

Top module: `mdio_responder`

## Requirements
- R1: While reset is asserted, and afterwards until a matching read reaches its turnaround, `mdio_oe` is 0. All registers reset to 16'h0000.
- R2: Bits are sampled at the MDC rising edge. While idle, a 0 followed by a 1 starts a frame. Any number of leading ones, including none, is accepted before the 0.
- R3: The two bits after the start pattern select the operation: 10 is a read and 01 is a write. For 00 or 11 the frame is dropped, and the block looks for a start pattern again from the next bit on.
- R4: Next come a 5-bit device address and a 5-bit register address, each sent MSB first. If the device address differs from `phy_addr`, the block never drives during the following 18 bit times, changes no register, and then resumes hunting.
- R5: On a matching read, `mdio_oe` stays 0 during the first turnaround bit. During the second it is 1 with `mdio_o` = 0. Drive changes take effect after an MDC falling edge.
- R6: After the turnaround, the addressed register is driven for 16 bit times, MSB first. `mdio_oe` returns to 0 in the bit time that follows the last data bit.
- R7: On a matching write, the turnaround bits must be 1 then 0. If they are, the next 16 bits (MSB first) are stored in the addressed register. Any other turnaround drops the frame and leaves the register unchanged.
- R8: The 5-bit register address selects one of 32 independent registers, and a write changes only the register it addresses.
- R9: With `ld_en` high at a rising edge, `ld_data` is stored at `ld_addr`. If a management write to the same register completes on that same edge, the management write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock from the master |
| rst_n | input | 1 | Asynchronous active-low reset, synchronously released |
| phy_addr | input | 5 | Strapped device address |
| mdio_i | input | 1 | Sampled level of the management data line |
| mdio_o | output | 1 | Value driven on the line when enabled |
| mdio_oe | output | 1 | Line drive enable (0 = released) |
| ld_en | input | 1 | Local preload strobe |
| ld_addr | input | 5 | Register selected by a preload |
| ld_data | input | 16 | Value written by a preload |

## Verification
The hardest case to reach from the ports is a local preload and a management write landing on the same register at the same rising edge. The bench raises `ld_en` in the bit time that carries the final data bit of a write frame. Both updates therefore meet at the completing edge, and a later read shows which one was kept. A second awkward case is recovery after a bad opcode: a valid write frame follows the dropped bits with no idle gap, which shows that hunting resumes at once.

// File: rtl/mdio_resp_pkg.sv
package mdio_resp_pkg;
  typedef enum logic [2:0] {
    S_HUNT  = 3'd0,
    S_START = 3'd1,
    S_OP    = 3'd2,
    S_ADDR  = 3'd3,
    S_TA    = 3'd4,
    S_DATA  = 3'd5
  } frm_state_e;

  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_WRITE = 2'b01;
endpackage

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
  import mdio_resp_pkg::*;
#(
  parameter int PADDR_W = 5,
  parameter int RADDR_W = 5,
  parameter int DATA_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_i,
  input  logic [PADDR_W-1:0] phy_addr,
  output logic               rd_load,
  output logic [RADDR_W-1:0] reg_addr,
  output logic               wr_en,
  output logic [DATA_W-1:0]  wr_data
);
  localparam int AW    = PADDR_W + RADDR_W;
  localparam int CMAX  = (AW > DATA_W) ? AW : DATA_W;
  localparam int CNT_W = $clog2(CMAX + 1);

  frm_state_e         state_q, state_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               first_q, first_d;
  logic               rd_q, rd_d;
  logic               hit_q, hit_d;
  logic [AW-1:0]      addr_q, addr_d;
  logic [DATA_W-1:0]  data_q, data_d;
  logic [AW-1:0]      addr_shift;

  assign addr_shift = {addr_q[AW-2:0], bit_i};

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    first_d = first_q;
    rd_d    = rd_q;
    hit_d   = hit_q;
    addr_d  = addr_q;
    data_d  = data_q;
    rd_load = 1'b0;
    wr_en   = 1'b0;
    case (state_q)
      S_HUNT: if (!bit_i) state_d = S_START;
      S_START: if (bit_i) begin
        state_d = S_OP;
        cnt_d   = '0;
      end
      S_OP: begin
        if (cnt_q == '0) begin
          first_d = bit_i;
          cnt_d   = CNT_W'(1);
        end else if ({first_q, bit_i} == OP_READ || {first_q, bit_i} == OP_WRITE) begin
          rd_d    = ({first_q, bit_i} == OP_READ);
          state_d = S_ADDR;
          cnt_d   = '0;
        end else begin
          state_d = S_HUNT;
        end
      end
      S_ADDR: begin
        addr_d = addr_shift;
        if (cnt_q == CNT_W'(AW - 1)) begin
          hit_d   = (addr_shift[AW-1:RADDR_W] == phy_addr);
          state_d = S_TA;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      S_TA: begin
        if (cnt_q == '0) begin
          first_d = bit_i;
          rd_load = hit_q & rd_q;
          cnt_d   = CNT_W'(1);
        end else if (hit_q && !rd_q && !(first_q && !bit_i)) begin
          state_d = S_HUNT;
        end else begin
          state_d = S_DATA;
          cnt_d   = '0;
        end
      end
      S_DATA: begin
        data_d = {data_q[DATA_W-2:0], bit_i};
        if (cnt_q == CNT_W'(DATA_W - 1)) begin
          wr_en   = hit_q & ~rd_q;
          state_d = S_HUNT;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = S_HUNT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_HUNT;
      cnt_q   <= '0;
      first_q <= 1'b0;
      rd_q    <= 1'b0;
      hit_q   <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      first_q <= first_d;
      rd_q    <= rd_d;
      hit_q   <= hit_d;
      addr_q  <= addr_d;
      data_q  <= data_d;
    end
  end

  assign reg_addr = addr_q[RADDR_W-1:0];
  assign wr_data  = {data_q[DATA_W-2:0], bit_i};

  // R3: an invalid opcode (00 or 11) sends the parser back to hunting
  assert_bad_op_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_OP && cnt_q == CNT_W'(1) && first_q == bit_i) |=> state_q == S_HUNT);

  // R7: a matching write with a turnaround other than 10 is dropped
  assert_bad_ta_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_TA && cnt_q == CNT_W'(1) && hit_q && !rd_q && !(first_q && !bit_i))
      |=> state_q == S_HUNT);

  // R4: neither a write nor a reply may start for another device's frame
  assert_no_act_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en || rd_load) |-> (addr_q[AW-1:RADDR_W] == phy_addr));
endmodule

// File: rtl/mdio_regfile.sv
module mdio_regfile #(
  parameter int RADDR_W = 5,
  parameter int DATA_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [RADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               ld_en,
  input  logic [RADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0]  ld_data,
  input  logic [RADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0]  rd_data
);
  localparam int DEPTH = 1 << RADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    logic              upd_en;
    logic [DATA_W-1:0] upd_val;

    always_comb begin
      upd_en  = 1'b0;
      upd_val = mem_q[g];
      if (wr_en && wr_addr == RADDR_W'(g)) begin
        upd_en  = 1'b1;
        upd_val = wr_data;
      end else if (ld_en && ld_addr == RADDR_W'(g)) begin
        upd_en  = 1'b1;
        upd_val = ld_data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mem_q[g] <= '0;
      else if (upd_en) mem_q[g] <= upd_val;
    end
  end

  assign rd_data = mem_q[rd_addr];

  // R9: a preload without a colliding management write lands
  assert_preload_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && !(wr_en && wr_addr == ld_addr)) |=> mem_q[$past(ld_addr)] == $past(ld_data));

  // R9: the management write wins any collision
  assert_wr_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mem_q[$past(wr_addr)] == $past(wr_data));
endmodule

// File: rtl/mdio_tx_drv.sv
module mdio_tx_drv #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] word,
  output logic              pad_o,
  output logic              pad_oe
);
  localparam int LEN   = DATA_W + 1;
  localparam int LEN_W = $clog2(LEN + 1);

  logic [DATA_W:0]  sh_q, sh_d;
  logic [LEN_W-1:0] left_q, left_d;

  always_comb begin
    sh_d   = sh_q;
    left_d = left_q;
    if (load) begin
      sh_d   = {1'b0, word};
      left_d = LEN_W'(LEN);
    end else if (left_q != '0) begin
      sh_d   = {sh_q[DATA_W-1:0], 1'b0};
      left_d = left_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
    end else begin
      sh_q   <= sh_d;
      left_q <= left_d;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pad_o  <= 1'b0;
      pad_oe <= 1'b0;
    end else begin
      pad_o  <= sh_q[DATA_W];
      pad_oe <= (left_q != '0);
    end
  end

  // R5: the first bit driven after a released stretch is the zero of the turnaround
  assert_ta_zero_R5: assert property (@(negedge clk) disable iff (!rst_n)
    $rose(pad_oe) |-> (pad_o == 1'b0));

  // R6: a new reply never starts while one is still being driven
  assert_no_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (left_q == '0));
endmodule

// File: rtl/mdio_responder.sv
module mdio_responder #(
  parameter int PADDR_W = 5,
  parameter int RADDR_W = 5,
  parameter int DATA_W  = 16
) (
  input  logic               mdc,
  input  logic               rst_n,
  input  logic [PADDR_W-1:0] phy_addr,
  input  logic               mdio_i,
  output logic               mdio_o,
  output logic               mdio_oe,
  input  logic               ld_en,
  input  logic [RADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0]  ld_data
);
  logic               rd_load;
  logic [RADDR_W-1:0] reg_addr;
  logic               wr_en;
  logic [DATA_W-1:0]  wr_data;
  logic [DATA_W-1:0]  rd_data;

  mdio_frame_fsm #(.PADDR_W(PADDR_W), .RADDR_W(RADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk(mdc), .rst_n(rst_n), .bit_i(mdio_i), .phy_addr(phy_addr),
    .rd_load(rd_load), .reg_addr(reg_addr), .wr_en(wr_en), .wr_data(wr_data)
  );

  mdio_regfile #(.RADDR_W(RADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(mdc), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(reg_addr), .wr_data(wr_data),
    .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .rd_addr(reg_addr), .rd_data(rd_data)
  );

  mdio_tx_drv #(.DATA_W(DATA_W)) u_tx (
    .clk(mdc), .rst_n(rst_n), .load(rd_load), .word(rd_data),
    .pad_o(mdio_o), .pad_oe(mdio_oe)
  );

  // R1: the line stays released while reset is held
  always_comb begin
    if (!rst_n) assert_reset_release_R1: assert (!mdio_oe);
  end
endmodule

// File: tb/mdio_responder_bench.sv
module mdio_responder_bench;
  localparam time PERIOD = 400ns;
  localparam logic [4:0] MY_PHY = 5'h0B;

  logic        mdc = 1'b0;
  logic        rst_n;
  logic        m_oe, m_bit;
  logic        ld_en;
  logic [4:0]  ld_addr;
  logic [15:0] ld_data;
  logic        mdio_o, mdio_oe;
  wire         bus = mdio_oe ? mdio_o : (m_oe ? m_bit : 1'b1);

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  mdio_responder u_mdio_responder (
    .mdc(mdc), .rst_n(rst_n), .phy_addr(MY_PHY), .mdio_i(bus),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data)
  );

  always #(PERIOD/2) mdc = ~mdc;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic drive_bit(input logic b);
    @(negedge mdc); #1;
    m_oe = 1'b1; m_bit = b;
  endtask

  task automatic free_slot(output logic oe_s, output logic b_s);
    @(negedge mdc); #1;
    m_oe = 1'b0;
    oe_s = mdio_oe; b_s = bus;
  endtask

  task automatic idle(input int n);
    logic a, b;
    for (int i = 0; i < n; i++) free_slot(a, b);
  endtask

  task automatic header(input bit pre, input logic [1:0] op, input logic [4:0] phy,
                        input logic [4:0] ra);
    if (pre) for (int i = 0; i < 32; i++) drive_bit(1'b1);
    drive_bit(1'b0); drive_bit(1'b1);
    drive_bit(op[1]); drive_bit(op[0]);
    for (int i = 4; i >= 0; i--) drive_bit(phy[i]);
    for (int i = 4; i >= 0; i--) drive_bit(ra[i]);
  endtask

  task automatic mdio_write(input bit pre, input logic [4:0] phy, input logic [4:0] ra,
                            input logic [15:0] d, input logic [1:0] ta, input bit collide,
                            input logic [15:0] ld_val);
    header(pre, 2'b01, phy, ra);
    drive_bit(ta[1]); drive_bit(ta[0]);
    for (int i = 15; i >= 0; i--) drive_bit(d[i]);
    if (collide) begin
      ld_en = 1'b1; ld_addr = ra; ld_data = ld_val;
    end
    idle(1);
    ld_en = 1'b0;
    idle(3);
  endtask

  task automatic mdio_read(input bit pre, input logic [4:0] phy, input logic [4:0] ra,
                           output logic [15:0] d, output logic ta1_oe, output logic ta2_oe,
                           output logic ta2_bit, output logic any_oe, output logic post_oe);
    logic o, b;
    header(pre, 2'b10, phy, ra);
    free_slot(ta1_oe, b);
    free_slot(ta2_oe, ta2_bit);
    any_oe = ta1_oe | ta2_oe;
    d = '0;
    for (int i = 0; i < 16; i++) begin
      free_slot(o, b);
      d = {d[14:0], b};
      any_oe |= o;
    end
    free_slot(post_oe, b);
    idle(3);
  endtask

  task automatic read_expect(input string req, input bit pre, input logic [4:0] ra,
                             input logic [15:0] exp);
    logic [15:0] d; logic t1, t2, tb, an, po;
    mdio_read(pre, MY_PHY, ra, d, t1, t2, tb, an, po);
    check(d == exp, req, d, exp);
  endtask

  task automatic t_reset();
    check(mdio_oe == 1'b0, "R1 oe after reset", mdio_oe, 0);
    read_expect("R1 reset value", 1, 5'd20, 16'h0000);
  endtask

  task automatic t_preamble_rw();
    logic [15:0] d; logic t1, t2, tb, an, po;
    mdio_write(1, MY_PHY, 5'd3, 16'hA5C3, 2'b10, 0, 16'h0);
    mdio_read(1, MY_PHY, 5'd3, d, t1, t2, tb, an, po);
    check(d == 16'hA5C3, "R7 write/read data", d, 16'hA5C3);
    check(t1 == 1'b0, "R5 first TA released", t1, 0);
    check(t2 == 1'b1 && tb == 1'b0, "R5 second TA drives 0", {t2, tb}, 2);
    check(po == 1'b0, "R6 release after last bit", po, 0);
  endtask

  task automatic t_no_preamble();
    mdio_write(0, MY_PHY, 5'd7, 16'h1234, 2'b10, 0, 16'h0);
    read_expect("R2 no preamble", 0, 5'd7, 16'h1234);
    read_expect("R6 MSB first", 0, 5'd3, 16'hA5C3);
  endtask

  task automatic t_mismatch();
    logic [15:0] d; logic t1, t2, tb, an, po;
    mdio_write(1, MY_PHY ^ 5'h01, 5'd3, 16'hFFFF, 2'b10, 0, 16'h0);
    read_expect("R4 foreign write ignored", 1, 5'd3, 16'hA5C3);
    mdio_read(1, MY_PHY ^ 5'h10, 5'd3, d, t1, t2, tb, an, po);
    check(an == 1'b0 && po == 1'b0, "R4 foreign read not driven", an, 0);
    check(d == 16'hFFFF, "R4 foreign read line high", d, 16'hFFFF);
  endtask

  task automatic t_bad_op();
    drive_bit(1'b0); drive_bit(1'b1); drive_bit(1'b0); drive_bit(1'b0);
    mdio_write(0, MY_PHY, 5'd9, 16'h0F0F, 2'b10, 0, 16'h0);
    read_expect("R3 hunt after op 00", 0, 5'd9, 16'h0F0F);
    header(0, 2'b11, MY_PHY, 5'd9);
    for (int i = 0; i < 18; i++) drive_bit(1'b1);
    idle(4);
    read_expect("R3 op 11 dropped", 0, 5'd9, 16'h0F0F);
  endtask

  task automatic t_bad_ta();
    mdio_write(1, MY_PHY, 5'd9, 16'h0000, 2'b11, 0, 16'h0);
    read_expect("R7 bad TA 11 dropped", 1, 5'd9, 16'h0F0F);
    mdio_write(1, MY_PHY, 5'd9, 16'h0000, 2'b00, 0, 16'h0);
    read_expect("R7 bad TA 00 dropped", 1, 5'd9, 16'h0F0F);
  endtask

  task automatic t_preload();
    @(negedge mdc); #1;
    ld_en = 1'b1; ld_addr = 5'd1; ld_data = 16'h796D;
    @(negedge mdc); #1;
    ld_en = 1'b0;
    read_expect("R9 preload visible", 1, 5'd1, 16'h796D);
    mdio_write(1, MY_PHY, 5'd2, 16'hBEEF, 2'b10, 1, 16'h4444);
    read_expect("R9 write wins collision", 1, 5'd2, 16'hBEEF);
  endtask

  task automatic t_all_regs();
    for (int r = 0; r < 32; r++)
      mdio_write(0, MY_PHY, 5'(r), 16'(r * 16'h0421) ^ 16'h8001, 2'b10, 0, 16'h0);
    for (int r = 0; r < 32; r++)
      read_expect("R8 register independence", 0, 5'(r), 16'(r * 16'h0421) ^ 16'h8001);
  endtask

  initial begin
    rst_n = 1'b0; m_oe = 1'b0; m_bit = 1'b1;
    ld_en = 1'b0; ld_addr = '0; ld_data = '0;
    repeat (3) @(negedge mdc);
    check(mdio_oe == 1'b0, "R1 oe during reset", mdio_oe, 0);
    #1 rst_n = 1'b1;
    idle(4);
    t_reset();
    t_preamble_rw();
    t_no_preamble();
    t_mismatch();
    t_bad_op();
    t_bad_ta();
    t_preload();
    t_all_regs();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule